// File: doc/BRIEF.md
# Dual-Channel Over-Temperature Warning and Power-Good Combiner

This block watches two temperature-sense codes. Each code is compared with its own protection threshold plus a small warning margin, and the block raises a warning flag for that channel. Each channel's margin, qualification delay and power-good coupling come from one 8-bit settings byte. The qualification delay is either a long debounce, nominally 100 ms and counted in clock cycles derived from the clock-frequency parameter, or none at all. A warning drops on the first clock edge at which the sense code is no longer above the warning level.

The block also forms an active-high power-good signal per channel. Power-good goes low while any of that channel's always-included faults is present: undervoltage, supply off, soft-start filter, or the shared memory-CRC fault. Channel A can also include an AC-sense fault when a separate enable is set. When a channel's trigger bit is set, its own warning also pulls that channel's power-good low. The sense converter, the protection shutdown and the register access are outside this block.

Top module: `otw_pgood_top`

## Requirements
- R1: Warning level = protection code + offset code + 1, computed without loss. A channel's raw condition is true only when its sense code is strictly greater than that level. Offset codes 0, 1, 2 and 3 give a margin of 1, 2, 3 or 4 LSBs (3.125 mV per LSB).
- R2: Settings byte fields: bit 3 is channel A no-debounce, bit 2 is channel A power-good trigger, bits [1:0] are channel A offset. Bit 7 is channel B no-debounce, bit 6 is channel B trigger, bits [5:4] are channel B offset.
- R3: With a no-debounce bit of 0, the warning rises at the DB-th consecutive clock edge at which the raw condition holds. DB = (CLK_HZ/1000)*DEBOUNCE_MS. Any edge with the condition false restarts the count.
- R4: With a no-debounce bit of 1, the warning rises at the first clock edge at which the raw condition holds. This also applies when the bit is set partway through a count.
- R5: A warning clears at the first clock edge at which its raw condition is false.
- R6: pgood_a_o is low while uv_a_i, supply_off_a_i, ss_filt_a_i or crc_err_i is high. pgood_b_o is low while uv_b_i, supply_off_b_i, ss_filt_b_i or crc_err_i is high.
- R7: ac_sense_i pulls pgood_a_o low only while ac_incl_i is 1. It never affects pgood_b_o.
- R8: When a channel's trigger bit is 1, that channel's active warning pulls its power-good low. When the bit is 0, the warning has no effect on power-good.
- R9: The channels are independent. The inputs and settings of one channel never change the other channel's warning or power-good, except through the shared crc_err_i.
- R10: While rst_ni is low, both warnings are 0 and the debounce counts are cleared. Power-good then follows the fault inputs alone.
- R11: A warning level above the largest sense code never wraps. For example, protection 255 with offset code 3 raises no warning, even at sense 255.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_i | input | 8 | Settings byte (R2 layout) |
| sense_a_i | input | CODE_W | Channel A temperature-sense code |
| prot_a_i | input | CODE_W | Channel A protection threshold code |
| sense_b_i | input | CODE_W | Channel B temperature-sense code |
| prot_b_i | input | CODE_W | Channel B protection threshold code |
| uv_a_i | input | 1 | Channel A undervoltage fault |
| supply_off_a_i | input | 1 | Channel A supply-off fault |
| ss_filt_a_i | input | 1 | Channel A soft-start filter fault |
| uv_b_i | input | 1 | Channel B undervoltage fault |
| supply_off_b_i | input | 1 | Channel B supply-off fault |
| ss_filt_b_i | input | 1 | Channel B soft-start filter fault |
| crc_err_i | input | 1 | Memory CRC fault, shared by both channels |
| ac_sense_i | input | 1 | AC-sense fault, optional for channel A |
| ac_incl_i | input | 1 | Include ac_sense_i in channel A power-good |
| warn_a_o | output | 1 | Channel A over-temperature warning |
| warn_b_o | output | 1 | Channel B over-temperature warning |
| pgood_a_o | output | 1 | Channel A power-good, active high |
| pgood_b_o | output | 1 | Channel B power-good, active high |

## Verification
A debounce count that is off by one shows at the warning port as a rise one edge early or late after DB raw edges. A count that fails to restart after a dropped condition shows as a warning well before DB edges have passed since the drop. A wrong threshold sum or a wrapped carry shows at once, within one edge, as a warning at a sense code one LSB too low or too high. Faulty power-good aggregation is combinational, so it shows in the same cycle that a fault input or setting bit changes. Because every output is compared with a behavioural model on each clock, any of these errors is reported in the cycle it first appears.

// File: rtl/otw_pkg.sv
package otw_pkg;
  localparam int NCH = 2;

  typedef struct packed {
    logic       no_wait;
    logic       to_pg;
    logic [1:0] off;
  } ch_cfg_t;

  function automatic ch_cfg_t cfg_field(input logic [7:0] b, input int ch);
    return ch_cfg_t'(b[ch*4 +: 4]);
  endfunction
endpackage

// File: rtl/otw_thresh.sv
module otw_thresh #(
  parameter int CODE_W = 8
) (
  input  logic [CODE_W-1:0] sense_i,
  input  logic [CODE_W-1:0] prot_i,
  input  logic [1:0]        off_i,
  output logic              above_o
);
  localparam int SUM_W = CODE_W + 1;

  logic [SUM_W-1:0] lvl;

  // extra bit keeps the sum from wrapping
  always_comb begin
    lvl     = {1'b0, prot_i} + SUM_W'(off_i) + SUM_W'(1);
    above_o = {1'b0, sense_i} > lvl;
  end

  always_comb begin
    if (above_o) begin
      AST_NO_WRAP: assert (sense_i > prot_i); // R11
      AST_MIN_MARGIN: assert ((int'(sense_i) - int'(prot_i)) >= 2); // R1
    end
  end
endmodule

// File: rtl/otw_debounce.sv
module otw_debounce #(
  parameter int CNT_LIM = 5000000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic raw_i,
  input  logic no_wait_i,
  output logic warn_o
);
  localparam int CW = $clog2(CNT_LIM + 1);

  logic [CW-1:0] cnt_q;
  logic          warn_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      warn_q <= 1'b0;
    end else if (!raw_i) begin
      cnt_q  <= '0;
      warn_q <= 1'b0;
    end else if (!warn_q) begin
      if (no_wait_i || cnt_q == CW'(CNT_LIM - 1)) warn_q <= 1'b1;
      else cnt_q <= cnt_q + 1'b1;
    end
  end

  assign warn_o = warn_q;

  AST_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !raw_i |=> !warn_q); // R5
  AST_BYPASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    raw_i && no_wait_i |=> warn_q); // R4
  AST_NO_EARLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(warn_q) && !$past(no_wait_i) |-> $past(cnt_q) == CW'(CNT_LIM - 1)); // R3
  AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < CW'(CNT_LIM)); // R3
endmodule

// File: rtl/pgood_agg.sv
module pgood_agg #(
  parameter int NFIX = 4
) (
  input  logic [NFIX-1:0] fix_i,
  input  logic            opt_i,
  input  logic            opt_en_i,
  input  logic            warn_i,
  input  logic            trig_i,
  output logic            pgood_o
);
  logic fault;

  always_comb begin
    fault   = (|fix_i) | (opt_i & opt_en_i) | (warn_i & trig_i);
    pgood_o = ~fault;
  end

  always_comb begin
    if (!trig_i && !opt_en_i && fix_i == '0)
      AST_TRIG_OFF: assert (pgood_o); // R8
    if (fix_i != '0)
      AST_FIXED_LOW: assert (!pgood_o); // R6
  end
endmodule

// File: rtl/otw_pgood_top.sv
module otw_pgood_top
  import otw_pkg::*;
#(
  parameter int CODE_W      = 8,
  parameter int CLK_HZ      = 50000000,
  parameter int DEBOUNCE_MS = 100
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [7:0]        cfg_i,
  input  logic [CODE_W-1:0] sense_a_i,
  input  logic [CODE_W-1:0] prot_a_i,
  input  logic [CODE_W-1:0] sense_b_i,
  input  logic [CODE_W-1:0] prot_b_i,
  input  logic              uv_a_i,
  input  logic              supply_off_a_i,
  input  logic              ss_filt_a_i,
  input  logic              uv_b_i,
  input  logic              supply_off_b_i,
  input  logic              ss_filt_b_i,
  input  logic              crc_err_i,
  input  logic              ac_sense_i,
  input  logic              ac_incl_i,
  output logic              warn_a_o,
  output logic              warn_b_o,
  output logic              pgood_a_o,
  output logic              pgood_b_o
);
  localparam int DB_RAW = (CLK_HZ / 1000) * DEBOUNCE_MS;
  localparam int DB_CYC = (DB_RAW < 1) ? 1 : DB_RAW;
  localparam int NFIX   = 4;

  logic [CODE_W-1:0] sense [NCH];
  logic [CODE_W-1:0] prot  [NCH];
  logic [NFIX-1:0]   fix   [NCH];
  logic [NCH-1:0]    opt, opt_en, raw, warn, pg;

  always_comb begin
    sense[0]  = sense_a_i;
    sense[1]  = sense_b_i;
    prot[0]   = prot_a_i;
    prot[1]   = prot_b_i;
    fix[0]    = {uv_a_i, supply_off_a_i, ss_filt_a_i, crc_err_i};
    fix[1]    = {uv_b_i, supply_off_b_i, ss_filt_b_i, crc_err_i};
    opt[0]    = ac_sense_i;
    opt[1]    = 1'b0;
    opt_en[0] = ac_incl_i;
    opt_en[1] = 1'b0;
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    ch_cfg_t cc;
    assign cc = cfg_field(cfg_i, c);

    otw_thresh #(.CODE_W(CODE_W)) u_thr (
      .sense_i (sense[c]),
      .prot_i  (prot[c]),
      .off_i   (cc.off),
      .above_o (raw[c])
    );

    otw_debounce #(.CNT_LIM(DB_CYC)) u_db (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .raw_i     (raw[c]),
      .no_wait_i (cc.no_wait),
      .warn_o    (warn[c])
    );

    pgood_agg #(.NFIX(NFIX)) u_pg (
      .fix_i    (fix[c]),
      .opt_i    (opt[c]),
      .opt_en_i (opt_en[c]),
      .warn_i   (warn[c]),
      .trig_i   (cc.to_pg),
      .pgood_o  (pg[c])
    );
  end

  assign warn_a_o  = warn[0];
  assign warn_b_o  = warn[1];
  assign pgood_a_o = pg[0];
  assign pgood_b_o = pg[1];

  AST_RST_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(warn_a_o) |-> $past(rst_ni)); // R10
  AST_AC_B_FREE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !uv_b_i && !supply_off_b_i && !ss_filt_b_i && !crc_err_i && !warn_b_o |-> pgood_b_o); // R7
endmodule

// File: tb/tb_otw_pgood_top.sv
module tb_otw_pgood_top;
  localparam int CODE_W = 8;
  localparam int CLK_HZ = 20000;
  localparam int DB_MS  = 100;
  localparam int DB     = (CLK_HZ / 1000) * DB_MS;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [7:0] cfg = 8'h00;
  logic [CODE_W-1:0] sense_a = '0, prot_a = '0, sense_b = '0, prot_b = '0;
  logic uv_a = 0, off_a = 0, ss_a = 0, uv_b = 0, off_b = 0, ss_b = 0;
  logic crc = 0, ac = 0, ac_incl = 0;
  logic warn_a, warn_b, pg_a, pg_b;

  int vectors = 0, errors = 0;
  bit done = 0;
  string tag = "R10";

  int run [2];
  bit mw [2];

  always #10 clk = ~clk;

  otw_pgood_top #(.CODE_W(CODE_W), .CLK_HZ(CLK_HZ), .DEBOUNCE_MS(DB_MS)) dut (
    .clk_i(clk), .rst_ni(rst_n), .cfg_i(cfg),
    .sense_a_i(sense_a), .prot_a_i(prot_a), .sense_b_i(sense_b), .prot_b_i(prot_b),
    .uv_a_i(uv_a), .supply_off_a_i(off_a), .ss_filt_a_i(ss_a),
    .uv_b_i(uv_b), .supply_off_b_i(off_b), .ss_filt_b_i(ss_b),
    .crc_err_i(crc), .ac_sense_i(ac), .ac_incl_i(ac_incl),
    .warn_a_o(warn_a), .warn_b_o(warn_b), .pgood_a_o(pg_a), .pgood_b_o(pg_b)
  );

  // behavioural model: run length of the raw condition per channel
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < 2; c++) begin run[c] = 0; mw[c] = 0; end
    end else begin
      for (int c = 0; c < 2; c++) begin
        int s, p, lvl;
        bit raw, nw;
        s   = (c == 0) ? int'(sense_a) : int'(sense_b);
        p   = (c == 0) ? int'(prot_a) : int'(prot_b);
        lvl = p + ((int'(cfg) >> (4 * c)) & 3) + 1;
        nw  = cfg[4 * c + 3];
        raw = s > lvl;
        if (raw) run[c]++; else run[c] = 0;
        mw[c] = raw && (mw[c] || nw || run[c] >= DB);
      end
    end
  end

  task automatic cmp(string t, string what, logic act, logic exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%b expected=%b t=%0t", t, what, act, exp, $time);
    end
  endtask

  task automatic chk_all();
    logic epa, epb;
    epa = !(uv_a | off_a | ss_a | crc | (ac_incl & ac) | (cfg[2] & mw[0]));
    epb = !(uv_b | off_b | ss_b | crc | (cfg[6] & mw[1]));
    cmp(tag, "warn_a", warn_a, mw[0]);
    cmp(tag, "warn_b", warn_b, mw[1]);
    cmp(tag, "pgood_a", pg_a, epa);
    cmp(tag, "pgood_b", pg_b, epb);
  endtask

  task automatic step(int n);
    repeat (n) begin @(negedge clk); chk_all(); end
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    // R10 reset state
    tag = "R10";
    step(3);
    cmp("R10", "warn_a in reset", warn_a, 1'b0);
    cmp("R10", "pgood_a in reset", pg_a, 1'b1);
    rst_n = 1'b1;
    step(2);

    // R1 R2: channel A offsets, no debounce
    prot_a = 8'd50;
    for (int code = 0; code < 4; code++) begin
      tag = "R1";
      cfg = 8'h08 | 8'(code);
      sense_a = 8'(50 + code + 1);
      step(2);
      cmp("R1", "warn_a at level", warn_a, 1'b0);
      sense_a = 8'(50 + code + 2);
      step(1);
      cmp("R1", "warn_a above level", warn_a, 1'b1);
      tag = "R5";
      sense_a = '0;
      step(1);
      cmp("R5", "warn_a release", warn_a, 1'b0);
    end

    // R2 R9: channel B field positions
    prot_b = 8'd80;
    for (int code = 0; code < 4; code++) begin
      tag = "R2";
      cfg = 8'h80 | 8'(code << 4);
      sense_b = 8'(80 + code + 1);
      step(2);
      cmp("R2", "warn_b at level", warn_b, 1'b0);
      sense_b = 8'(80 + code + 2);
      step(1);
      cmp("R2", "warn_b above level", warn_b, 1'b1);
      cmp("R9", "warn_a untouched", warn_a, 1'b0);
      sense_b = '0;
      step(1);
    end

    // R3 debounce with restart
    tag = "R3";
    cfg = 8'h00;
    prot_a = 8'd100;
    sense_a = 8'd102;
    step(1500);
    cmp("R3", "warn_a mid count", warn_a, 1'b0);
    sense_a = 8'd101;
    step(1);
    sense_a = 8'd102;
    step(DB - 1);
    cmp("R3", "warn_a one edge short", warn_a, 1'b0);
    step(1);
    cmp("R3", "warn_a after DB edges", warn_a, 1'b1);
    tag = "R5";
    sense_a = 8'd101;
    step(1);
    cmp("R5", "warn_a release after debounce", warn_a, 1'b0);

    // R4 bypass set partway through a count
    tag = "R4";
    sense_a = 8'd102;
    step(10);
    cmp("R4", "warn_a counting", warn_a, 1'b0);
    cfg = 8'h08;
    step(1);
    cmp("R4", "warn_a after bypass", warn_a, 1'b1);

    // R8 trigger coupling
    tag = "R8";
    cfg = 8'h0C;
    step(1);
    cmp("R8", "pgood_a with trigger", pg_a, 1'b0);
    cfg = 8'h08;
    step(1);
    cmp("R8", "pgood_a trigger off", pg_a, 1'b1);
    sense_a = '0;
    tag = "R9";
    cfg = 8'hC0;
    sense_b = 8'd82;
    step(1);
    cmp("R8", "pgood_b with trigger", pg_b, 1'b0);
    cmp("R9", "pgood_a independent", pg_a, 1'b1);
    sense_b = '0;
    cfg = 8'h00;
    step(2);

    // R6 fixed fault sources
    tag = "R6";
    uv_a = 1; step(1); cmp("R6", "pgood_a uv", pg_a, 1'b0); uv_a = 0;
    off_a = 1; step(1); cmp("R6", "pgood_a off", pg_a, 1'b0);
    cmp("R9", "pgood_b not hit by A", pg_b, 1'b1); off_a = 0;
    ss_a = 1; step(1); cmp("R6", "pgood_a ss", pg_a, 1'b0); ss_a = 0;
    crc = 1; step(1); cmp("R6", "pgood_a crc", pg_a, 1'b0);
    cmp("R6", "pgood_b crc", pg_b, 1'b0); crc = 0;
    uv_b = 1; step(1); cmp("R6", "pgood_b uv", pg_b, 1'b0); uv_b = 0;
    off_b = 1; step(1); cmp("R6", "pgood_b off", pg_b, 1'b0); off_b = 0;
    ss_b = 1; step(1); cmp("R6", "pgood_b ss", pg_b, 1'b0); ss_b = 0;
    step(1);

    // R7 optional AC-sense
    tag = "R7";
    ac = 1; ac_incl = 0; step(1);
    cmp("R7", "pgood_a ac excluded", pg_a, 1'b1);
    ac_incl = 1; step(1);
    cmp("R7", "pgood_a ac included", pg_a, 1'b0);
    cmp("R7", "pgood_b ac never", pg_b, 1'b1);
    ac = 0; ac_incl = 0; step(1);

    // R11 no wrap near top of range
    tag = "R11";
    cfg = 8'h0B;
    prot_a = 8'd255;
    sense_a = 8'd255;
    step(3);
    cmp("R11", "warn_a no wrap", warn_a, 1'b0);
    prot_a = 8'd250;
    step(1);
    cmp("R11", "warn_a near top", warn_a, 1'b1);
    sense_a = '0;
    step(2);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule